// File: doc/BRIEF.md
# Audio FIFO Interrupt Status Unit

This block watches the receive and transmit FIFOs of an audio serial port. It compares each FIFO level against programmable thresholds and detects pushes into a full FIFO and pops from an empty one. From these it derives three conditions per direction: data-available, overflow and underflow. All six are presented twice in one 32-bit status word: a raw copy, and a copy masked by an interrupt-enable word. The masked copies are combined into a single interrupt line.

Data-available is a level condition that follows the FIFO level in the same cycle. Overflow and underflow are sticky. Each is held by a small two-state machine with the states `ST_CLEAR` and `ST_SET`. The transition `SET_EVT` moves it to `ST_SET` when the error event is seen. The transition `CLR_W1C` returns it to `ST_CLEAR` when software writes a one to its bit. The transition `CLR_FIFO` also returns it to `ST_CLEAR` when the FIFO of that direction is reset. Transmit has a low threshold, which drives data-available, and a high threshold, which drives a separate output.

Top module: `afis_status_unit`

## Requirements
- R1: Status bit 8 (raw receive data-available) is 1 exactly while `rx_level` is greater than or equal to the receive threshold `thr_word[4:0]`, in the same cycle.
- R2: Status bit 12 (raw transmit data-available) is 1 exactly while `tx_level` is less than or equal to `thr_word[20:16]`. `tx_high` is 1 exactly while `tx_level` is greater than or equal to `thr_word[28:24]`. Both follow in the same cycle.
- R3: A clock edge with a push while full sets the overflow flag of that direction: status bit 9 for receive, bit 13 for transmit. The flag is visible after that edge.
- R4: A clock edge with a pop while empty sets the underflow flag of that direction: status bit 10 for receive, bit 14 for transmit. The flag is visible after that edge.
- R5: A clock edge with `clr_we` high clears each sticky flag whose bit is 1 in `clr_data`, at either its masked position (1, 2, 5, 6) or its raw position (9, 10, 13, 14). Zero bits in `clr_data` have no effect, and nothing changes while `clr_we` is low.
- R6: `rx_fifo_clr` clears only the receive sticky flags, and `tx_fifo_clr` clears only the transmit sticky flags, at the next edge. A FIFO clear wins over an error event in the same cycle.
- R7: An error event in the same cycle as a write-one-to-clear of the same flag leaves the flag set. With no event, no clear and no FIFO clear, a sticky flag keeps its value.
- R8: Status bits 0–2 and 4–6 are the raw bits 8–10 and 12–14, each ANDed with the `irq_en` bit of the same low position. Enable bits other than 0–2 and 4–6 have no effect. Status bits 3, 7, 11 and 15–31 read 0.
- R9: `irq` is 1 exactly when any of status bits 0–6 is 1.
- R10: After reset, all sticky flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_push | input | 1 | Receive FIFO push strobe |
| rx_pop | input | 1 | Receive FIFO pop strobe |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_empty | input | 1 | Receive FIFO empty flag |
| rx_fifo_clr | input | 1 | Receive FIFO reset; clears receive sticky flags |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_push | input | 1 | Transmit FIFO push strobe |
| tx_pop | input | 1 | Transmit FIFO pop strobe |
| tx_full | input | 1 | Transmit FIFO full flag |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| tx_fifo_clr | input | 1 | Transmit FIFO reset; clears transmit sticky flags |
| thr_word | input | 32 | Thresholds: receive [4:0], transmit low [20:16], transmit high [28:24] |
| irq_en | input | 32 | Interrupt enable word, bits 0–2 and 4–6 used |
| clr_we | input | 1 | Write strobe for write-one-to-clear |
| clr_data | input | 32 | Write-one-to-clear data |
| status | output | 32 | Masked status [6:0], raw status [14:8] |
| tx_high | output | 1 | Transmit level at or above the high threshold |
| irq | output | 1 | Interrupt line |

## Verification
Data-available, `tx_high`, the masked bits and `irq` have no register between the inputs and the outputs, so they are due in the same cycle the levels, thresholds or enables change. The sticky flags pass through one register and are due right after the first rising edge that sees the event, clear or FIFO reset. The bench changes inputs just after a rising edge and compares every output at the following falling edge. At that point a behavioural model has already absorbed the edge, so each result is checked in the cycle it is due and never earlier.

// File: rtl/afis_pkg.sv
package afis_pkg;
    typedef enum logic {ST_CLEAR, ST_SET} flag_st_t;

    localparam int THR_W    = 5;
    localparam int RAW_OFS  = 8;
    localparam int TX_OFS   = 4;
    localparam int POS_DA   = 0;
    localparam int POS_OVF  = 1;
    localparam int POS_UDF  = 2;
    localparam int RX_THR_L = 0;
    localparam int TX_LO_L  = 16;
    localparam int TX_HI_L  = 24;
endpackage

// File: rtl/afis_sticky.sv
module afis_sticky
    import afis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic w1c,
    input  logic fifo_clr,
    output logic flag
);
    flag_st_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAR;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_CLEAR: if (set_evt && !fifo_clr) nxt = ST_SET;           // SET_EVT
            ST_SET: begin
                if (fifo_clr)              nxt = ST_CLEAR;              // CLR_FIFO
                else if (w1c && !set_evt)  nxt = ST_CLEAR;              // CLR_W1C
            end
        endcase
    end

    always_comb flag = (state == ST_SET);
endmodule

// File: rtl/afis_dir.sv
module afis_dir
    import afis_pkg::*;
#(
    parameter int LVL_W = 6,
    parameter bit IS_TX = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [THR_W-1:0] thr_a,
    input  logic [THR_W-1:0] thr_b,
    input  logic             push,
    input  logic             pop,
    input  logic             full,
    input  logic             empty,
    input  logic             fifo_clr,
    input  logic [2:0]       w1c_bits,
    output logic [2:0]       cond,
    output logic             hi_hit
);
    logic [1:0] evt;
    logic [1:0] flg;

    always_comb begin
        evt[0] = push && full;
        evt[1] = pop && empty;
    end

    generate
        if (IS_TX) begin : g_tx
            always_comb begin
                cond[POS_DA] = (level <= LVL_W'(thr_a));
                hi_hit       = (level >= LVL_W'(thr_b));
            end
        end else begin : g_rx
            always_comb begin
                cond[POS_DA] = (level >= LVL_W'(thr_a));
                hi_hit       = 1'b0;
            end
        end
    endgenerate

    for (genvar k = 0; k < 2; k++) begin : g_flag
        afis_sticky u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_evt  (evt[k]),
            .w1c      (w1c_bits[k+1]),
            .fifo_clr (fifo_clr),
            .flag     (flg[k])
        );
    end

    always_comb begin
        cond[POS_OVF] = flg[0];
        cond[POS_UDF] = flg[1];
    end
endmodule

// File: rtl/afis_status_unit.sv
module afis_status_unit
    import afis_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             rx_full,
    input  logic             rx_empty,
    input  logic             rx_fifo_clr,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             tx_push,
    input  logic             tx_pop,
    input  logic             tx_full,
    input  logic             tx_empty,
    input  logic             tx_fifo_clr,
    input  logic [31:0]      thr_word,
    input  logic [31:0]      irq_en,
    input  logic             clr_we,
    input  logic [31:0]      clr_data,
    output logic [31:0]      status,
    output logic             tx_high,
    output logic             irq
);
    logic [2:0] rx_cond, tx_cond, rx_w1c, tx_w1c;
    logic       rx_hi_unused;
    logic [6:0] raw, masked;

    always_comb begin
        rx_w1c = clr_we ? (clr_data[2:0] | clr_data[RAW_OFS+2:RAW_OFS]) : 3'b000;
        tx_w1c = clr_we ? (clr_data[TX_OFS+2:TX_OFS]
                         | clr_data[RAW_OFS+TX_OFS+2:RAW_OFS+TX_OFS]) : 3'b000;
    end

    afis_dir #(.LVL_W(LVL_W), .IS_TX(1'b0)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (rx_level),
        .thr_a    (thr_word[RX_THR_L +: THR_W]),
        .thr_b    (thr_word[RX_THR_L +: THR_W]),
        .push     (rx_push),
        .pop      (rx_pop),
        .full     (rx_full),
        .empty    (rx_empty),
        .fifo_clr (rx_fifo_clr),
        .w1c_bits (rx_w1c),
        .cond     (rx_cond),
        .hi_hit   (rx_hi_unused)
    );

    afis_dir #(.LVL_W(LVL_W), .IS_TX(1'b1)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (tx_level),
        .thr_a    (thr_word[TX_LO_L +: THR_W]),
        .thr_b    (thr_word[TX_HI_L +: THR_W]),
        .push     (tx_push),
        .pop      (tx_pop),
        .full     (tx_full),
        .empty    (tx_empty),
        .fifo_clr (tx_fifo_clr),
        .w1c_bits (tx_w1c),
        .cond     (tx_cond),
        .hi_hit   (tx_high)
    );

    always_comb begin
        raw    = {tx_cond, 1'b0, rx_cond};
        masked = raw & irq_en[6:0] & 7'b1110111;
        status = {16'b0, 1'b0, raw, 1'b0, masked};
        irq    = |masked;
    end
endmodule

// File: rtl/afis_status_unit_chk.sv
module afis_status_unit_chk #(
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             rx_full,
    input logic             rx_empty,
    input logic             rx_fifo_clr,
    input logic [LVL_W-1:0] tx_level,
    input logic             tx_push,
    input logic             tx_pop,
    input logic             tx_full,
    input logic             tx_empty,
    input logic             tx_fifo_clr,
    input logic [31:0]      thr_word,
    input logic [31:0]      irq_en,
    input logic             clr_we,
    input logic [31:0]      clr_data,
    input logic [31:0]      status,
    input logic             tx_high,
    input logic             irq
);
    a_r3_rx_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_fifo_clr) |=> status[9]);

    a_r4_tx_udf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_empty && !tx_fifo_clr) |=> status[14]);

    a_r5_rx_ovf_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_data[9] && !(rx_push && rx_full)) |=> !status[9]);

    a_r6_rx_fifo_clr: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_clr |=> (!status[9] && !status[10]));

    a_r7_tx_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status[13] && !tx_fifo_clr && !(clr_we && (clr_data[5] || clr_data[13])))
        |=> status[13]);

    a_r8_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status[31:15] == 17'b0) && !status[11] && !status[7] && !status[3]);

    a_r9_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|status[6:0]));
endmodule

bind afis_status_unit afis_status_unit_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/afis_status_unit_bench.sv
`timescale 1ns/1ps
module afis_status_unit_bench;
    localparam int LVL_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LVL_W-1:0] rx_level = '0, tx_level = 6'd8;
    logic rx_push = 0, rx_pop = 0, rx_full = 0, rx_empty = 0, rx_fifo_clr = 0;
    logic tx_push = 0, tx_pop = 0, tx_full = 0, tx_empty = 0, tx_fifo_clr = 0;
    logic [31:0] thr_word = {3'b0, 5'd20, 3'b0, 5'd2, 11'b0, 5'd4};
    logic [31:0] irq_en = 32'h177;
    logic clr_we = 0;
    logic [31:0] clr_data = '0;
    logic [31:0] status;
    logic tx_high, irq;

    int compared = 0, mismatched = 0, cycles = 0;
    bit m_rxo = 0, m_rxu = 0, m_txo = 0, m_txu = 0;

    always #2.5 clk = ~clk;

    afis_status_unit #(.LVL_W(LVL_W)) u_afis_status_unit (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Reference model of the sticky flags: updated at each rising edge.
    function automatic bit nxt_flag(bit cur, bit evt, bit w1c, bit fclr);
        if (fclr) return 1'b0;   // R6
        if (evt)  return 1'b1;   // R3 R4 R7
        if (w1c)  return 1'b0;   // R5
        return cur;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rxo = 0; m_rxu = 0; m_txo = 0; m_txu = 0;   // R10
        end else begin
            m_rxo = nxt_flag(m_rxo, rx_push && rx_full, clr_we && (clr_data[1] || clr_data[9]),  rx_fifo_clr);
            m_rxu = nxt_flag(m_rxu, rx_pop && rx_empty, clr_we && (clr_data[2] || clr_data[10]), rx_fifo_clr);
            m_txo = nxt_flag(m_txo, tx_push && tx_full, clr_we && (clr_data[5] || clr_data[13]), tx_fifo_clr);
            m_txu = nxt_flag(m_txu, tx_pop && tx_empty, clr_we && (clr_data[6] || clr_data[14]), tx_fifo_clr);
        end
    end

    // Compare every output at each falling edge.
    always @(negedge clk) begin
        logic [6:0] raw, msk;
        int rxl, txl;
        rxl = int'(rx_level);
        txl = int'(tx_level);
        raw = '0;
        raw[0] = (rxl >= int'(thr_word[4:0]));    // R1
        raw[1] = m_rxo;
        raw[2] = m_rxu;
        raw[4] = (txl <= int'(thr_word[20:16]));  // R2
        raw[5] = m_txo;
        raw[6] = m_txu;
        msk = raw & irq_en[6:0];
        msk[3] = 1'b0;
        cycles++;
        chk("R1 rx data-available", 32'(status[8]), 32'(raw[0]));
        chk("R2 tx data-available", 32'(status[12]), 32'(raw[4]));
        chk("R2 tx_high", 32'(tx_high), 32'(txl >= int'(thr_word[28:24])));
        chk("R3 overflow flags", {status[13], status[9]}, {raw[5], raw[1]});
        chk("R4 underflow flags", {status[14], status[10]}, {raw[6], raw[2]});
        chk("R8 masked bits", 32'(status[6:0]), 32'(msk));
        chk("R8 spare bits", {status[31:15], status[11], status[7], status[3]}, 32'd0);
        chk("R9 irq", 32'(irq), 32'(|msk));
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
        rx_fifo_clr = 0; tx_fifo_clr = 0; clr_we = 0; clr_data = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 status in reset", status, 32'd0);
        #1 rst_n = 1'b1;
        tick();
        @(negedge clk);
        chk("R10 status after reset", status, 32'd0);

        // R1 R2: level sweeps
        for (int i = 0; i <= 32; i++) begin
            tick();
            rx_level = LVL_W'(i);
            tx_level = LVL_W'(32 - i);
        end

        // R3: receive overflow, flag appears after the edge
        tick();
        rx_push = 1; rx_full = 1;
        tick();
        quiet(); rx_full = 0;
        @(negedge clk);
        chk("R3 rx overflow set", 32'(status[9]), 32'd1);

        // R4: transmit underflow
        tick();
        tx_pop = 1; tx_empty = 1;
        tick();
        quiet(); tx_empty = 0;
        @(negedge clk);
        chk("R4 tx underflow set", 32'(status[14]), 32'd1);

        // R8: enable patterns, unused enable bits have no effect
        tick(); irq_en = 32'h0;
        @(negedge clk);
        chk("R8 all disabled", 32'(status[6:0]), 32'd0);
        chk("R9 irq low when disabled", 32'(irq), 32'd0);
        tick(); irq_en = 32'hFFFF_FF88;
        @(negedge clk);
        chk("R8 unused enables ignored", 32'(irq), 32'd0);
        tick(); irq_en = 32'h40;
        @(negedge clk);
        chk("R9 irq from tx underflow", 32'(irq), 32'd1);
        tick(); irq_en = 32'h177;

        // R5: zero bits and clr_we low do nothing
        tick(); clr_data = 32'hFFFF_FFFF;
        tick(); clr_data = 32'hFFFF_B999; clr_we = 1;
        tick(); quiet();
        @(negedge clk);
        chk("R5 no clear without ones", {status[14], status[9]}, 32'd3);
        // R5: clear at masked position and at raw position
        tick(); clr_we = 1; clr_data = 32'h0000_0002;
        tick(); clr_data = 32'h0000_4000;
        tick(); quiet();
        @(negedge clk);
        chk("R5 w1c both positions", {status[14], status[9]}, 32'd0);

        // R7: event and clear together keeps flag
        tick(); tx_push = 1; tx_full = 1; clr_we = 1; clr_data = 32'h2020;
        tick(); quiet(); tx_full = 0;
        @(negedge clk);
        chk("R7 set beats w1c", 32'(status[13]), 32'd1);

        // R6: receive FIFO clear leaves transmit flags alone, wins over event
        tick(); rx_pop = 1; rx_empty = 1;
        tick(); quiet();
        tick(); rx_fifo_clr = 1; rx_push = 1; rx_full = 1;
        tick(); quiet(); rx_full = 0; rx_empty = 0;
        @(negedge clk);
        chk("R6 rx clear", {status[10], status[9]}, 32'd0);
        chk("R6 tx untouched", 32'(status[13]), 32'd1);
        tick(); tx_fifo_clr = 1;
        tick(); quiet();
        @(negedge clk);
        chk("R6 tx clear", 32'(status[13]), 32'd0);

        // Mixed pseudo-random traffic, checked by the model each cycle
        for (int n = 0; n < 3000; n++) begin
            tick();
            rx_level = LVL_W'($urandom_range(0, 32));
            tx_level = LVL_W'($urandom_range(0, 32));
            rx_push = 1'($urandom); rx_pop = 1'($urandom);
            tx_push = 1'($urandom); tx_pop = 1'($urandom);
            rx_full = ($urandom_range(0, 3) == 0); rx_empty = ($urandom_range(0, 3) == 0);
            tx_full = ($urandom_range(0, 3) == 0); tx_empty = ($urandom_range(0, 3) == 0);
            rx_fifo_clr = ($urandom_range(0, 15) == 0);
            tx_fifo_clr = ($urandom_range(0, 15) == 0);
            clr_we = ($urandom_range(0, 3) == 0);
            clr_data = $urandom;
            if ((n % 64) == 0) begin
                irq_en = $urandom;
                thr_word = $urandom;
            end
        end
        tick(); quiet();
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule